// File: doc/BRIEF.md
# Compare Timer Channel with Watchdog Reset Routing

A single 16-bit timer channel controlled over a small register bus. A power-of-two prescaler turns either the core clock or a slow tick input into counting ticks. The counter steps up, or down when reversed, once per tick. Two comparators watch the counter and each sets a sticky flag when its match rule holds. The configuration part of the setup word can be written only once after reset. The count-enable and flag bits stay live after that.

The second comparator governs the counter. When it matches, the counter either restarts from zero or halts with counting disabled. Its flag can also drive a system reset request. Software arms the channel once and then keeps it alive by periodically clearing the flag, zeroing the counter and reloading the period. If software stops doing so, the flag rises and the reset request follows. Two enable bits route each flag to a shared interrupt line.

Top module: `cmp_timer_chan`

## Requirements
- R1: After reset every register (compare 1, compare 2, counter, setup, control) reads 0, and `irq` and `reset_req` are 0.
- R2: Registers are 16 bits at byte offsets 0 (compare 1), 2 (compare 2), 4 (counter), 6 (setup) and 8 (control). The control register holds bit 0 = compare-1 interrupt enable, bit 1 = compare-2 interrupt enable and bit 2 = reset enable. A counter write loads the counter and overrides that cycle's step.
- R3: Setup bits 3:0 hold N, and the counter advances once per 2^N source pulses.
- R4: Setup bit 4 selects the source: 0 means every clock, 1 means each cycle in which `slow_tick` is high.
- R5: Setup bit 5 set makes the counter decrement on each tick instead of incrementing.
- R6: Setup bits 7:6 and 9:8 give the compare-1 and compare-2 modes, each 0 = off, 1 = equal, 2 = greater-or-equal, 3 = equal or terminal count. The terminal count is 0xFFFF counting up and 0 counting down. A comparator is judged on the counter value present at a tick. A hit sets the sticky flag in setup bit 13 (compare 1) or bit 14 (compare 2). Writing 1 to a flag bit clears it, and a hit in the same cycle wins over the clear.
- R7: In greater-or-equal mode the flag is set again on every tick while counter >= compare, so it reappears after being cleared.
- R8: On a compare-2 hit, the counter goes to 0 if setup bit 11 is clear. If bit 11 is set, the counter holds its value and setup bit 15 is cleared.
- R9: Setup bit 12 is set by the first setup write. From then on, writes leave bits 11:0 unchanged, while bits 13, 14 and 15 still respond to writes.
- R10: `irq` is high exactly when a flag is set and its interrupt enable bit is set.
- R11: `reset_req` is high exactly when the compare-2 flag is set and the reset enable bit is set. Clearing the flag, zeroing the counter and reloading compare 2 before expiry keeps it low.
- R12: With setup bit 15 clear the counter holds its value and the prescaler is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | Alternate count source, one pulse per cycle high |
| bus_addr | input | 4 | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| irq | output | 1 | Enabled flags ORed together |
| reset_req | output | 1 | Watchdog reset request |

## Verification
The hardest situation to reach is a counter halted by a compare-2 stop under a setup word that is already frozen. Only the flag and count-enable bits can still be changed at that point, so each scenario begins from a fresh reset and makes its one configuring write first. The watchdog scenario makes that first write with counting off, so that the zero compare value cannot fire. It then loads the period and starts the counter with a flag-clearing write. Before expiry it repeats the clear, zero and reload sequence several times with fewer ticks than the period between them. Only after that does it let the channel lapse and checks that the counter froze at the period.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int TMR_W  = 16;
    localparam int NCMP   = 2;
    localparam int DIV_W  = 4;
    localparam int CMP_WD = 1;

    typedef enum logic [1:0] {
        CM_OFF = 2'd0,
        CM_EQ  = 2'd1,
        CM_GE  = 2'd2,
        CM_EVT = 2'd3
    } cmp_mode_e;

    // word index = byte address >> 1
    localparam logic [2:0] RI_CMP1  = 3'd0;
    localparam logic [2:0] RI_CMP2  = 3'd1;
    localparam logic [2:0] RI_CNT   = 3'd2;
    localparam logic [2:0] RI_SETUP = 3'd3;
    localparam logic [2:0] RI_CTL   = 3'd4;

    localparam int SB_CLKSEL = 4;
    localparam int SB_REV    = 5;
    localparam int SB_MODE   = 6;
    localparam int SB_STOP   = 11;
    localparam int SB_LOCK   = 12;
    localparam int SB_FLAG   = 13;
    localparam int SB_RUN    = 15;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             src,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int PRE_W = (1 << SEL_W) - 1;

    logic [PRE_W-1:0] pre_d, pre_q, mask;

    always_comb begin
        for (int b = 0; b < PRE_W; b++) begin
            mask[b] = (b < int'(sel));
        end
        tick = run && src && ((pre_q & mask) == mask);
        if (!run) begin
            pre_d = '0;
        end else if (src) begin
            pre_d = pre_q + 1'b1;
        end else begin
            pre_d = pre_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_d;
        end
    end
endmodule

// File: rtl/tmr_compare.sv
module tmr_compare
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cmp,
    input  cmp_mode_e    mode,
    input  logic         down,
    output logic         hit
);
    logic eq, term;

    always_comb begin
        eq   = (cnt == cmp);
        term = down ? (cnt == '0) : (cnt == '1);
        unique case (mode)
            CM_OFF:  hit = 1'b0;
            CM_EQ:   hit = eq;
            CM_GE:   hit = (cnt >= cmp);
            CM_EVT:  hit = eq || term;
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/cmp_timer_chan.sv
module cmp_timer_chan
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [TMR_W-1:0]  bus_wdata,
    output logic [TMR_W-1:0]  bus_rdata,
    output logic              irq,
    output logic              reset_req
);
    localparam int W   = TMR_W;
    localparam int IXW = ADDR_W - 1;

    typedef struct packed {
        logic [NCMP-1:0][W-1:0] cmp;
        logic [W-1:0]           cnt;
        logic [DIV_W-1:0]       div;
        logic                   clk_sel;
        logic                   rev;
        logic                   stop_en;
        logic                   locked;
        logic                   run;
        logic [NCMP-1:0][1:0]   mode;
        logic [NCMP-1:0]        flag;
        logic [NCMP-1:0]        irq_en;
        logic                   rst_en;
    } st_t;

    st_t st_d, st_q;

    logic [IXW-1:0]  widx;
    logic            wr_setup, wr_cnt, wr_ctl;
    logic [NCMP-1:0] wr_cmp;
    logic [NCMP-1:0] hit;
    logic            tick;
    logic [W-1:0]    setup_rd, ctl_rd;

    tmr_prescale #(.SEL_W(DIV_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (st_q.run),
        .src   (st_q.clk_sel ? slow_tick : 1'b1),
        .sel   (st_q.div),
        .tick  (tick)
    );

    for (genvar g = 0; g < NCMP; g++) begin : g_cmp
        tmr_compare #(.W(W)) u_cmp (
            .cnt  (st_q.cnt),
            .cmp  (st_q.cmp[g]),
            .mode (cmp_mode_e'(st_q.mode[g])),
            .down (st_q.rev),
            .hit  (hit[g])
        );
    end

    always_comb begin
        widx     = bus_addr[ADDR_W-1:1];
        wr_setup = bus_we && (widx == IXW'(RI_SETUP));
        wr_cnt   = bus_we && (widx == IXW'(RI_CNT));
        wr_ctl   = bus_we && (widx == IXW'(RI_CTL));
        wr_cmp[0] = bus_we && (widx == IXW'(RI_CMP1));
        wr_cmp[1] = bus_we && (widx == IXW'(RI_CMP2));

        setup_rd = {st_q.run, st_q.flag, st_q.locked, st_q.stop_en, 1'b0,
                    st_q.mode, st_q.rev, st_q.clk_sel, st_q.div};
        ctl_rd   = {{(W-NCMP-1){1'b0}}, st_q.rst_en, st_q.irq_en};

        unique case (widx)
            IXW'(RI_CMP1):  bus_rdata = st_q.cmp[0];
            IXW'(RI_CMP2):  bus_rdata = st_q.cmp[1];
            IXW'(RI_CNT):   bus_rdata = st_q.cnt;
            IXW'(RI_SETUP): bus_rdata = setup_rd;
            IXW'(RI_CTL):   bus_rdata = ctl_rd;
            default:        bus_rdata = '0;
        endcase

        irq       = |(st_q.flag & st_q.irq_en);
        reset_req = st_q.flag[CMP_WD] && st_q.rst_en;
    end

    always_comb begin
        st_d = st_q;

        // setup word: configuration frozen after the first write
        if (wr_setup) begin
            if (!st_q.locked) begin
                st_d.div     = bus_wdata[DIV_W-1:0];
                st_d.clk_sel = bus_wdata[SB_CLKSEL];
                st_d.rev     = bus_wdata[SB_REV];
                for (int m = 0; m < NCMP; m++) begin
                    st_d.mode[m] = bus_wdata[SB_MODE + 2*m +: 2];
                end
                st_d.stop_en = bus_wdata[SB_STOP];
                st_d.locked  = 1'b1;
            end
            st_d.run  = bus_wdata[SB_RUN];
            st_d.flag = st_q.flag & ~bus_wdata[SB_FLAG +: NCMP];
        end

        // prescaled tick: flags, then counter step / wrap / stop
        if (tick) begin
            st_d.flag = st_d.flag | hit;
            if (hit[CMP_WD]) begin
                if (st_q.stop_en) begin
                    st_d.run = 1'b0;
                end else begin
                    st_d.cnt = '0;
                end
            end else if (st_q.rev) begin
                st_d.cnt = st_q.cnt - 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end

        if (wr_cnt) begin
            st_d.cnt = bus_wdata;
        end
        for (int c = 0; c < NCMP; c++) begin
            if (wr_cmp[c]) begin
                st_d.cmp[c] = bus_wdata;
            end
        end
        if (wr_ctl) begin
            st_d.irq_en = bus_wdata[NCMP-1:0];
            st_d.rst_en = bus_wdata[NCMP];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/cmp_timer_chan_chk.sv
module cmp_timer_chan_chk #(
    parameter int W      = 16,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [W-1:0]      bus_wdata,
    input logic              tick,
    input logic [W-1:0]      setup_word,
    input logic [W-1:0]      cnt,
    input logic [1:0]        irq_en,
    input logic              rst_en,
    input logic              irq,
    input logic              reset_req
);
    logic setup_wr;
    assign setup_wr = bus_we && (bus_addr[ADDR_W-1:1] == (ADDR_W-1)'(3));

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(setup_word[12]) |-> setup_word[12]); // R9

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(setup_word[12]) |-> $stable(setup_word[11:0])); // R9

    AST_FLAG_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(setup_word[14]) |-> $past(setup_wr && bus_wdata[14])); // R6

    AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(bus_we) && !$past(tick)) |-> $stable(cnt)); // R12

    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(setup_word[15]) && !$past(bus_we)) |-> $stable(cnt)); // R8

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == 2'b00) |-> !irq); // R10

    AST_RESET_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_en |-> !reset_req); // R11
endmodule

bind cmp_timer_chan cmp_timer_chan_chk #(.W(16), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .tick       (tick),
    .setup_word (setup_rd),
    .cnt        (st_q.cnt),
    .irq_en     (st_q.irq_en),
    .rst_en     (st_q.rst_en),
    .irq        (irq),
    .reset_req  (reset_req)
);

// File: tb/sim_cmp_timer_chan.sv
`timescale 1ns/1ps
module sim_cmp_timer_chan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_tick = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq, reset_req;

    int total = 0;
    int bad = 0;
    bit done = 0;

    localparam logic [3:0] A_CMP1 = 4'd0, A_CMP2 = 4'd2, A_CNT = 4'd4,
                           A_SET = 4'd6, A_CTL = 4'd8;

    always #4 clk = ~clk;

    cmp_timer_chan u0 (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq), .reset_req(reset_req)
    );

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_we = 1'b0; slow_tick = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(logic [3:0] a, logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        #1 bus_we = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        #1 d = bus_rdata;
    endtask

    task automatic t_reset_state();
        logic [15:0] v;
        do_reset();
        rd(A_CMP1, v); chk("R1 cmp1", v, 16'h0);
        rd(A_CMP2, v); chk("R1 cmp2", v, 16'h0);
        rd(A_CNT, v);  chk("R1 cnt", v, 16'h0);
        rd(A_SET, v);  chk("R1 setup", v, 16'h0);
        rd(A_CTL, v);  chk("R1 ctl", v, 16'h0);
        chk("R1 irq", {15'b0, irq}, 16'h0);
        chk("R1 reset_req", {15'b0, reset_req}, 16'h0);
    endtask

    task automatic t_map();
        logic [15:0] v;
        do_reset();
        wr(A_CMP1, 16'h1234); wr(A_CMP2, 16'hBEEF); wr(A_CNT, 16'h0042); wr(A_CTL, 16'h0007);
        rd(A_CMP1, v); chk("R2 cmp1", v, 16'h1234);
        rd(A_CMP2, v); chk("R2 cmp2", v, 16'hBEEF);
        rd(A_CNT, v);  chk("R2 cnt", v, 16'h0042);
        rd(A_CTL, v);  chk("R2 ctl", v, 16'h0007);
    endtask

    task automatic t_prescale();
        logic [15:0] v;
        do_reset();
        wr(A_SET, 16'h8002);          // run, divide by 4
        repeat (39) @(posedge clk);   // 40 source pulses with stop edge
        wr(A_SET, 16'h0000);
        rd(A_CNT, v); chk("R3 divide by 4", v, 16'd10);
        repeat (10) @(posedge clk);
        rd(A_CNT, v); chk("R12 hold when disabled", v, 16'd10);
    endtask

    task automatic t_slow_src();
        logic [15:0] v;
        do_reset();
        wr(A_SET, 16'h8010);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk) slow_tick = 1'b1;
            @(negedge clk) slow_tick = 1'b0;
            repeat (2) @(posedge clk);
        end
        repeat (20) @(posedge clk);
        wr(A_SET, 16'h0000);
        rd(A_CNT, v); chk("R4 slow source count", v, 16'd5);
    endtask

    task automatic t_reverse();
        logic [15:0] v;
        do_reset();
        wr(A_CNT, 16'd10);
        wr(A_SET, 16'h8020);
        repeat (3) @(posedge clk);
        wr(A_SET, 16'h0000);
        rd(A_CNT, v); chk("R5 count down", v, 16'd6);
    endtask

    task automatic t_equal_irq();
        logic [15:0] v;
        do_reset();
        wr(A_CMP1, 16'd5);
        wr(A_SET, 16'h8040);          // cmp1 equal, cmp2 off
        repeat (9) @(posedge clk);
        wr(A_SET, 16'h0000);
        rd(A_SET, v); chk("R6 equal flag, cmp2 off", v, 16'h3040);
        rd(A_CNT, v); chk("R6 no wrap with cmp2 off", v, 16'd10);
        chk("R10 irq masked", {15'b0, irq}, 16'h0);
        wr(A_CTL, 16'h0001);
        chk("R10 irq cmp1 enabled", {15'b0, irq}, 16'h1);
        wr(A_CTL, 16'h0002);
        chk("R10 irq other enable", {15'b0, irq}, 16'h0);
        wr(A_SET, 16'h2000);
        rd(A_SET, v); chk("R6 write one clears", v, 16'h1040);
    endtask

    task automatic t_event_terminal(logic [15:0] setw, logic [15:0] exp_set, string tag);
        logic [15:0] v;
        do_reset();
        wr(A_CNT, 16'hFFFE);
        wr(A_CMP1, 16'h0100);
        wr(A_SET, setw);
        repeat (1) @(posedge clk);
        wr(A_SET, 16'h0000);
        rd(A_SET, v); chk(tag, v, exp_set);
        rd(A_CNT, v); chk("R6 counter rolled over", v, 16'h0000);
    endtask

    task automatic t_ge();
        logic [15:0] v;
        do_reset();
        wr(A_CMP1, 16'd3);
        wr(A_SET, 16'h8080);
        repeat (9) @(posedge clk);
        wr(A_SET, 16'h0000);
        wr(A_SET, 16'h2000);
        rd(A_SET, v); chk("R7 flag cleared", v, 16'h1080);
        wr(A_SET, 16'h8000);
        wr(A_SET, 16'h0000);
        rd(A_SET, v); chk("R7 flag set again at ge", v, 16'h3080);
        rd(A_CNT, v); chk("R7 counter", v, 16'd11);
    endtask

    task automatic t_wrap();
        logic [15:0] v;
        do_reset();
        wr(A_CMP2, 16'd4);
        wr(A_SET, 16'h8100);
        repeat (11) @(posedge clk);
        wr(A_SET, 16'h0000);
        rd(A_CNT, v); chk("R8 wrap after cmp2", v, 16'd2);
        rd(A_SET, v); chk("R8 cmp2 flag", v, 16'h5100);
    endtask

    task automatic t_stop();
        logic [15:0] v;
        do_reset();
        wr(A_CMP2, 16'd4);
        wr(A_SET, 16'h8900);
        repeat (20) @(posedge clk);
        rd(A_CNT, v); chk("R8 stop holds", v, 16'd4);
        rd(A_SET, v); chk("R8 run cleared", v, 16'h5900);
    endtask

    task automatic t_lock();
        logic [15:0] v;
        do_reset();
        wr(A_SET, 16'h0003);
        rd(A_SET, v); chk("R9 first write sets lock", v, 16'h1003);
        wr(A_SET, 16'h0FF5);
        rd(A_SET, v); chk("R9 config ignored", v, 16'h1003);
        wr(A_SET, 16'h8000);
        rd(A_SET, v); chk("R9 run still writable", v, 16'h9003);
        wr(A_SET, 16'h0000);
    endtask

    task automatic t_watchdog();
        logic [15:0] v;
        do_reset();
        wr(A_CTL, 16'h0004);
        wr(A_SET, 16'h0B00);          // cmp2 event mode, stop on hit, idle
        wr(A_CMP2, 16'd6);
        wr(A_CNT, 16'd0);
        wr(A_SET, 16'hC000);
        for (int k = 0; k < 3; k++) begin
            repeat (3) @(posedge clk);
            wr(A_SET, 16'hC000);
            wr(A_CNT, 16'd0);
            wr(A_CMP2, 16'd6);
        end
        chk("R11 kept alive", {15'b0, reset_req}, 16'h0);
        repeat (20) @(posedge clk);
        chk("R11 expired", {15'b0, reset_req}, 16'h1);
        chk("R10 irq off without enable", {15'b0, irq}, 16'h0);
        rd(A_CNT, v); chk("R8 frozen at period", v, 16'd6);
        wr(A_CTL, 16'h0000);
        chk("R11 disabled", {15'b0, reset_req}, 16'h0);
    endtask

    initial begin
        t_reset_state();
        t_map();
        t_prescale();
        t_slow_src();
        t_reverse();
        t_equal_irq();
        t_event_terminal(16'h80C0, 16'h30C0, "R6 event mode terminal hit");
        t_event_terminal(16'h8040, 16'h1040, "R6 equal mode no terminal hit");
        t_ge();
        t_wrap();
        t_stop();
        t_lock();
        t_watchdog();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got hung expected finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule